// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block is the digital half of a microcontroller supply supervisor. A threshold comparator outside the block reports whether the supply is good. From that flag the block derives a stretched system reset, in both polarities. It also gives an unstretched low-line flag and a chip-enable gate that blocks memory selects while the supply is low.

A watchdog runs alongside. Software must toggle a kick input within a selectable timeout. If it does not, the block issues a reset pulse of the same length as the power-on stretch and lowers a watchdog status flag. The status flag stays low until the next kick transition.

All durations are counted in ticks. A tick comes either from a prescaler on the system clock or from rising edges of a separate timing clock. A mode input picks the source. Every control input except the chip-enable input passes through a two-flop synchronizer.

Top module: `supply_supervisor`

## Requirements
- R1: `low_line_n` equals the supply-good input delayed by the two-flop synchronizer (two clock cycles), with no stretching in either direction.
- R2: `rst_out_n` is 0 while the synchronized supply flag is 0. After the flag returns to 1 it stays 0 for `RST_TICKS` further ticks. In internal mode with `TICK_DIV`=1 this is `RST_TICKS`+2 cycles counted from the input change.
- R3: `rst_out` is always the bitwise complement of `rst_out_n`.
- R4: When the watchdog expires, `rst_out_n` goes low for exactly the reset active time, and `wd_stat_n` goes to 0 on the same clock edge.
- R5: Both a rising and a falling transition of the synchronized kick input restart the watchdog count from zero.
- R6: While the synchronized `wd_disable` is 1, the watchdog count is held at zero, no watchdog reset occurs, and `wd_stat_n` is 1.
- R7: In internal mode, `wd_fast` = 1 selects a normal timeout of `WD_FAST_TICKS` and `wd_fast` = 0 selects `WD_SLOW_TICKS`.
- R8: The first watchdog period after any reset uses the long limit: `WD_SLOW_TICKS` in internal mode and `EXT_LONG_CNT` in external mode. This holds whatever `wd_fast` is. The period ends at the first kick transition.
- R9: `wd_stat_n` returns to 1 on the first kick transition after it went low. It is forced to 1 whenever the synchronized supply flag is 0.
- R10: `ce_out_n` equals `ce_in_n` while the synchronized supply flag is 1, and is 1 while it is 0.
- R11: With `ext_timing` = 1, ticks are rising edges of the synchronized `ext_tick_clk`, and the limits are `EXT_RST_CNT`, `EXT_WD_CNT` and `EXT_LONG_CNT`. `wd_fast` has no effect, and no timeout elapses while that clock is idle.
- R12: The watchdog count is held at zero while reset is asserted. It starts counting on the clock edge where reset deasserts, so with no kicks `rst_out_n` stays high for exactly the long period in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| supply_ok | input | 1 | Supply-good flag from the external comparator, 1 = above threshold |
| wd_kick | input | 1 | Watchdog kick; every transition restarts the timer |
| wd_disable | input | 1 | 1 = watchdog disabled (kick input undriven or at mid-level) |
| wd_fast | input | 1 | Internal mode timeout select, 1 = fast, 0 = slow |
| ext_timing | input | 1 | 1 = count ticks on the external timing clock |
| ext_tick_clk | input | 1 | External timing clock, sampled by the system clock |
| ce_in_n | input | 1 | Active-low chip-enable request |
| rst_out_n | output | 1 | Active-low system reset |
| rst_out | output | 1 | Active-high system reset |
| wd_stat_n | output | 1 | Watchdog status, 0 = a timeout occurred |
| low_line_n | output | 1 | Active-low immediate low-supply flag |
| ce_out_n | output | 1 | Gated active-low chip enable |

## Verification
The assertions assume that all control inputs other than `ce_in_n` are asynchronous levels, seen only after the synchronizer. They also assume that `ext_tick_clk` is slower than half the system clock, so every rising edge survives sampling. The stimulus changes inputs only on falling clock edges. It toggles the external timing clock at most once per cycle. The limit parameters it uses keep the long period longer than the fast one and every limit at least 3 ticks. A cycle-level reference model in the bench predicts each output for random supply drops, kick rates, disable and mode changes.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;

  // Synchronized control bundle.
  typedef struct packed {
    logic tick_clk;
    logic ext_mode;
    logic fast;
    logic wd_off;
    logic kick;
    logic sup_ok;
  } supv_ctl_t;

  localparam int unsigned CTL_W = $bits(supv_ctl_t);

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Watchdog limit in ticks for the current state and mode.
  function automatic int unsigned wd_period(input logic first, input logic fast,
                                            input logic ext,
                                            input int unsigned fast_t,
                                            input int unsigned slow_t,
                                            input int unsigned ext_t,
                                            input int unsigned ext_long_t);
    if (ext) return first ? ext_long_t : ext_t;
    if (first) return slow_t;
    return fast ? fast_t : slow_t;
  endfunction

  // Reset active time in ticks for the current mode.
  function automatic int unsigned active_period(input logic ext,
                                                input int unsigned int_t,
                                                input int unsigned ext_t);
    return ext ? ext_t : int_t;
  endfunction

endpackage

// File: rtl/supv_sync2.sv
`timescale 1ns/1ps
module supv_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/supv_timebase.sv
`timescale 1ns/1ps
module supv_timebase #(
  parameter int unsigned TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic tick_clk_s,
  output logic tick
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic int_tick;
  logic ext_tick;
  logic tick_clk_d;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign int_tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] div_q;
      logic             div_wrap;
      assign div_wrap = (div_q == DIV_W'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        div_q <= '0;
        else if (div_wrap) div_q <= '0;
        else               div_q <= div_q + 1'b1;
      end
      assign int_tick = div_wrap;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_clk_d <= 1'b0;
    else        tick_clk_d <= tick_clk_s;
  end

  assign ext_tick = tick_clk_s & ~tick_clk_d;
  assign tick     = ext_mode ? ext_tick : int_tick;
endmodule

// File: rtl/supv_rst_stretch.sv
`timescale 1ns/1ps
module supv_rst_stretch #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_ok,
  input  logic             wd_fire,
  input  logic             tick,
  input  logic [CNT_W-1:0] act_lim,
  output logic             rst_active
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             done;

  assign done = (cnt_q >= (act_lim - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (!sup_ok || wd_fire) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && tick) begin
      if (done) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_active = act_q;
endmodule

// File: rtl/supv_watchdog.sv
`timescale 1ns/1ps
module supv_watchdog #(
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned FAST_T     = 100,
  parameter int unsigned SLOW_T     = 1600,
  parameter int unsigned EXT_T      = 40,
  parameter int unsigned EXT_LONG_T = 640
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick_s,
  input  logic             wd_off,
  input  logic             fast_sel,
  input  logic             ext_mode,
  input  logic             tick,
  input  logic             hold,
  input  logic             sup_ok,
  output logic             kick_edge,
  output logic             wd_fire,
  output logic [CNT_W-1:0] wd_cnt,
  output logic             wd_stat_n
);
  logic             kick_d;
  logic             first_q;
  logic             stat_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_d <= 1'b0;
    else        kick_d <= kick_s;
  end

  assign kick_edge = kick_s ^ kick_d;
  assign lim = CNT_W'(supv_pkg::wd_period(first_q, fast_sel, ext_mode,
                                          FAST_T, SLOW_T, EXT_T, EXT_LONG_T));
  assign expired = (cnt_q >= (lim - CNT_W'(1)));
  assign wd_fire = !hold && !wd_off && !kick_edge && tick && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (hold || wd_off)   cnt_q <= '0;
    else if (kick_edge)        cnt_q <= '0;
    else if (tick) begin
      if (wd_fire) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         first_q <= 1'b1;
    else if (hold)      first_q <= 1'b1;
    else if (kick_edge) first_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 stat_q <= 1'b1;
    else if (!sup_ok || wd_off) stat_q <= 1'b1;
    else if (wd_fire)           stat_q <= 1'b0;
    else if (kick_edge)         stat_q <= 1'b1;
  end

  assign wd_cnt    = cnt_q;
  assign wd_stat_n = stat_q;
endmodule

// File: rtl/supply_supervisor.sv
`timescale 1ns/1ps
module supply_supervisor #(
  parameter int unsigned TICK_DIV      = 125000,
  parameter int unsigned RST_TICKS     = 50,
  parameter int unsigned WD_FAST_TICKS = 100,
  parameter int unsigned WD_SLOW_TICKS = 1600,
  parameter int unsigned EXT_RST_CNT   = 20,
  parameter int unsigned EXT_WD_CNT    = 40,
  parameter int unsigned EXT_LONG_CNT  = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wd_kick,
  input  logic wd_disable,
  input  logic wd_fast,
  input  logic ext_timing,
  input  logic ext_tick_clk,
  input  logic ce_in_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic wd_stat_n,
  output logic low_line_n,
  output logic ce_out_n
);
  import supv_pkg::*;

  localparam int unsigned WD_MAX  = umax(umax(WD_FAST_TICKS, WD_SLOW_TICKS),
                                         umax(EXT_WD_CNT, EXT_LONG_CNT));
  localparam int unsigned ALL_MAX = umax(WD_MAX, umax(RST_TICKS, EXT_RST_CNT));
  localparam int unsigned CNT_W   = $clog2(ALL_MAX + 1);

  supv_ctl_t        ctl_raw;
  supv_ctl_t        ctl_s;
  logic             supply_ok_s;
  logic             wd_off_s;
  logic             tick;
  logic             rst_active;
  logic             kick_edge;
  logic             wd_fire;
  logic [CNT_W-1:0] wd_cnt;
  logic [CNT_W-1:0] act_lim;

  assign ctl_raw = '{tick_clk: ext_tick_clk, ext_mode: ext_timing, fast: wd_fast,
                     wd_off: wd_disable, kick: wd_kick, sup_ok: supply_ok};

  supv_sync2 #(.W(CTL_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ctl_raw),
    .q_sync  (ctl_s)
  );

  assign supply_ok_s = ctl_s.sup_ok;
  assign wd_off_s    = ctl_s.wd_off;

  supv_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ctl_s.ext_mode),
    .tick_clk_s (ctl_s.tick_clk),
    .tick       (tick)
  );

  assign act_lim = CNT_W'(active_period(ctl_s.ext_mode, RST_TICKS, EXT_RST_CNT));

  supv_rst_stretch #(.CNT_W(CNT_W)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_ok     (supply_ok_s),
    .wd_fire    (wd_fire),
    .tick       (tick),
    .act_lim    (act_lim),
    .rst_active (rst_active)
  );

  supv_watchdog #(
    .CNT_W      (CNT_W),
    .FAST_T     (WD_FAST_TICKS),
    .SLOW_T     (WD_SLOW_TICKS),
    .EXT_T      (EXT_WD_CNT),
    .EXT_LONG_T (EXT_LONG_CNT)
  ) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_s    (ctl_s.kick),
    .wd_off    (wd_off_s),
    .fast_sel  (ctl_s.fast),
    .ext_mode  (ctl_s.ext_mode),
    .tick      (tick),
    .hold      (rst_active),
    .sup_ok    (supply_ok_s),
    .kick_edge (kick_edge),
    .wd_fire   (wd_fire),
    .wd_cnt    (wd_cnt),
    .wd_stat_n (wd_stat_n)
  );

  assign rst_out    = rst_active;
  assign rst_out_n  = ~rst_active;
  assign low_line_n = supply_ok_s;
  assign ce_out_n   = supply_ok_s ? ce_in_n : 1'b1;
endmodule

// File: rtl/supply_supervisor_chk.sv
`timescale 1ns/1ps
module supply_supervisor_chk #(
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned WD_MAX = 1600
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_out_n,
  input logic             wd_stat_n,
  input logic             low_line_n,
  input logic             supply_ok_s,
  input logic             wd_off_s,
  input logic             kick_edge,
  input logic             wd_fire,
  input logic             rst_active,
  input logic [CNT_W-1:0] wd_cnt
);
  p_lowline_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !low_line_n |=> !rst_out_n);

  p_fire_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> !rst_out_n);

  p_fire_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fire && supply_ok_s) |=> !wd_stat_n);

  p_kick_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_edge |=> (wd_cnt == '0));

  p_disable_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off_s |=> wd_stat_n);

  p_disable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off_s |=> (wd_cnt == '0));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < CNT_W'(WD_MAX));

  p_lowline_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !low_line_n |=> wd_stat_n);

  p_hold_in_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> (wd_cnt == '0));
endmodule

bind supply_supervisor supply_supervisor_chk #(.CNT_W(CNT_W), .WD_MAX(WD_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_out_n   (rst_out_n),
  .wd_stat_n   (wd_stat_n),
  .low_line_n  (low_line_n),
  .supply_ok_s (supply_ok_s),
  .wd_off_s    (wd_off_s),
  .kick_edge   (kick_edge),
  .wd_fire     (wd_fire),
  .rst_active  (rst_active),
  .wd_cnt      (wd_cnt)
);

// File: tb/supply_supervisor_test.sv
`timescale 1ns/1ps
module supply_supervisor_test;
  localparam int unsigned P_RST = 8, P_FAST = 12, P_SLOW = 30;
  localparam int unsigned P_ERST = 3, P_EWD = 5, P_ELONG = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup = 1'b0, kick = 1'b0, off = 1'b0, fast = 1'b1, ext = 1'b0, eclk = 1'b0, ce = 1'b1;
  logic rst_out_n, rst_out, wd_stat_n, low_line_n, ce_out_n;
  int vecs = 0, bad = 0;
  bit done = 1'b0;
  string cur_tag = "R2";

  always #4 clk = ~clk;

  supply_supervisor #(
    .TICK_DIV(1), .RST_TICKS(P_RST), .WD_FAST_TICKS(P_FAST), .WD_SLOW_TICKS(P_SLOW),
    .EXT_RST_CNT(P_ERST), .EXT_WD_CNT(P_EWD), .EXT_LONG_CNT(P_ELONG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(sup), .wd_kick(kick), .wd_disable(off),
    .wd_fast(fast), .ext_timing(ext), .ext_tick_clk(eclk), .ce_in_n(ce),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_stat_n(wd_stat_n),
    .low_line_n(low_line_n), .ce_out_n(ce_out_n)
  );

  // Requirement-level timing rules (R7, R8, R11).
  function automatic int f_wd_limit(bit first, bit fst, bit ex);
    if (ex) return first ? P_ELONG : P_EWD;
    return (first || !fst) ? P_SLOW : P_FAST;
  endfunction
  function automatic int f_act_limit(bit ex);
    return ex ? P_ERST : P_RST;
  endfunction

  // Reference model: a pipeline of two input stages, then elapsed-tick counters.
  bit [5:0] q1 = '0, q2 = '0;
  bit kprev = 0, eprev = 0;
  bit m_rst = 1, m_first = 1, m_stat = 1;
  int m_rel = 0, m_wel = 0;

  always @(posedge clk) begin : ref_model
    bit s_sup, s_kick, s_off, s_fast, s_ext, s_ecl, kedge, tk, fire;
    bit n_rst, n_first, n_stat;
    int n_rel, n_wel;
    if (!rst_n) begin
      q1 = '0; q2 = '0; kprev = 0; eprev = 0;
      m_rst = 1; m_first = 1; m_stat = 1; m_rel = 0; m_wel = 0;
    end else begin
      {s_ecl, s_ext, s_fast, s_off, s_kick, s_sup} = q2;
      kedge = s_kick ^ kprev;
      tk    = s_ext ? (s_ecl & ~eprev) : 1'b1;
      fire  = !m_rst && !s_off && !kedge && tk &&
              (m_wel + 1 >= f_wd_limit(m_first, s_fast, s_ext));
      n_rst = m_rst; n_rel = m_rel;
      if (!s_sup || fire) begin n_rst = 1; n_rel = 0; end
      else if (m_rst && tk) begin
        if (m_rel + 1 >= f_act_limit(s_ext)) begin n_rst = 0; n_rel = 0; end
        else n_rel = m_rel + 1;
      end
      if (m_rst || s_off || kedge) n_wel = 0;
      else if (tk) n_wel = fire ? 0 : m_wel + 1;
      else n_wel = m_wel;
      n_first = m_rst ? 1'b1 : (kedge ? 1'b0 : m_first);
      if (!s_sup || s_off) n_stat = 1;
      else if (fire)       n_stat = 0;
      else if (kedge)      n_stat = 1;
      else                 n_stat = m_stat;
      m_rst = n_rst; m_rel = n_rel; m_wel = n_wel; m_first = n_first; m_stat = n_stat;
      kprev = s_kick; eprev = s_ecl;
      q2 = q1;
      q1 = {eclk, ext, fast, off, kick, sup};
    end
  end

  task automatic chk(input string req, input logic got, input logic exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s [%s] t=%0t got %b exp %b", req, cur_tag, $time, got, exp);
    end
  endtask

  task automatic chk_int(input string req, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s [%s] t=%0t got %0d exp %0d", req, cur_tag, $time, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R2", rst_out_n, ~m_rst);
    chk("R3", rst_out, ~rst_out_n);
    chk("R1", low_line_n, q2[0]);
    chk("R9", wd_stat_n, m_stat);
    chk("R10", ce_out_n, q2[0] ? ce : 1'b1);
  endtask

  task automatic run_level(input logic lvl, output int n);
    n = 0;
    while (rst_out_n === lvl && n < 2000) begin
      n++;
      step();
    end
  endtask

  task automatic count_low(input int cycles, input int kick_every, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      if (kick_every > 0 && (i % kick_every) == 0) kick = ~kick;
      step();
      if (rst_out_n === 1'b0) lows++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog expired got hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin : main
    int n, lows;
    void'($urandom(32'd7351));
    repeat (4) step();
    chk("R2", rst_out_n, 1'b0);
    chk("R1", low_line_n, 1'b0);
    chk("R9", wd_stat_n, 1'b1);
    chk("R10", ce_out_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) step();

    // R2: supply returns, stretch = RST_TICKS + 2 synchronizer cycles
    cur_tag = "R2";
    sup = 1'b1;
    run_level(1'b0, n);
    chk_int("R2", n, P_RST + 2);
    // R8 R12: first period after reset is the long one even with fast selected
    cur_tag = "R8";
    run_level(1'b1, n);
    chk_int("R8", n, P_SLOW);
    cur_tag = "R4";
    chk("R4", wd_stat_n, 1'b0);
    run_level(1'b0, n);
    chk_int("R4", n, P_RST);
    // R7: one kick ends the long period, then the fast limit applies
    cur_tag = "R7";
    kick = ~kick;
    repeat (4) step();
    chk("R9", wd_stat_n, 1'b1);
    run_level(1'b1, n);
    chk_int("R7", n + 4, P_FAST + 3);
    run_level(1'b0, n);
    chk_int("R4", n, P_RST);

    // R5: kick toggling every 10 cycles with a 12-tick limit only works if both edges count
    cur_tag = "R5";
    count_low(300, 10, lows);
    chk_int("R5", lows, 0);

    // R6: disabled watchdog never fires
    cur_tag = "R6";
    off = 1'b1;
    count_low(200, 0, lows);
    chk_int("R6", lows, 0);
    chk("R6", wd_stat_n, 1'b1);
    off = 1'b0;
    count_low(5, 3, lows);

    // R1: low-line follows supply through the two-stage synchronizer only
    cur_tag = "R1";
    sup = 1'b0;
    step(); chk("R1", low_line_n, 1'b1);
    step(); chk("R1", low_line_n, 1'b0);
    // R10: chip enable gated while low
    cur_tag = "R10";
    ce = 1'b0;
    step(); chk("R10", ce_out_n, 1'b1);
    sup = 1'b1;
    step(); chk("R1", low_line_n, 1'b0);
    step(); chk("R1", low_line_n, 1'b1);
    chk("R10", ce_out_n, 1'b0);
    ce = 1'b1;
    step(); chk("R10", ce_out_n, 1'b1);
    run_level(1'b0, n);

    // R11: external timing, idle clock means no timeout
    cur_tag = "R11";
    ext = 1'b1;
    count_low(150, 0, lows);
    chk_int("R11", lows, 0);
    lows = 0;
    for (int i = 0; i < 400; i++) begin
      if (i % 2 == 0) eclk = ~eclk;
      if (i == 200) fast = ~fast;
      step();
      if (rst_out_n === 1'b0) lows++;
    end
    chk("R11", lows > 0, 1'b1);
    ext = 1'b0;

    // Random phase over all inputs
    cur_tag = "rand";
    for (int i = 0; i < 6000; i++) begin
      int unsigned kp;
      kp = ((i / 500) % 3 == 0) ? 3 : (((i / 500) % 3 == 1) ? 8 : 25);
      if (sup) begin if ($urandom % 400 == 0) sup = 1'b0; end
      else if ($urandom % 12 == 0) sup = 1'b1;
      if ($urandom % kp == 0) kick = ~kick;
      if ($urandom % 500 == 0) off = ~off;
      if ($urandom % 200 == 0) fast = ~fast;
      if (i >= 3000 && $urandom % 700 == 0) ext = ~ext;
      if ($urandom % 2 == 0) eclk = ~eclk;
      ce = 1'($urandom % 2);
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule